// File: doc/BRIEF.md
# Equivalent-Time Sample Placement Engine

This block builds a dense waveform record of a repeating signal from a sampler that runs much slower than the wanted record rate. The record is gathered over several acquisition passes. Each pass starts on a trigger pulse and takes a fixed number of real-time samples. The sampling instant sits at a different fractional offset from the trigger in each pass. The engine places every incoming sample into the record slot that matches its effective time position.

For example, with ten passes the record holds ten times as many points per unit time as one pass delivers. A 100 MS/s sampler then gives an effective 1 GS/s record. Slot numbers follow `slot = sample_number * pass_count + pass_offset`, so samples from different signal cycles end up interleaved by phase rather than stored in arrival order.

The method only gives a true picture of a periodic input, because each pass samples a different cycle of it. The record is usable only once every offset pass has been gathered. Trigger analog circuitry, period estimation and sample-clock phase stepping live outside this block. The pass offset it keeps is the index those neighbours act on.

Top module: `et_sample_placer`

## Requirements
- R1: After synchronous reset, `wr_en`, `rec_done` and `rec_valid` are low. The pass offset is 0.
- R2: While no pass is open, samples with `smp_valid` high are not written. A pass opens on the clock edge where `trig` is high. Samples are taken from the following cycle on.
- R3: During a pass, the k-th accepted sample (k counting from 0) appears on the write port one cycle after it is taken. The write has `wr_en` high, `wr_addr = k * P + offset` and `wr_data` equal to the sampled value. Cycles with `smp_valid` low produce no write.
- R4: A `trig` pulse while a pass is open is ignored. Sample numbering and the offset continue unchanged.
- R5: A pass closes after `SAMPLES` accepted samples. The offset then advances by one, and samples that arrive before the next trigger are not written.
- R6: The pass with offset P-1 closes the record. `rec_done` is high for exactly one cycle, the same cycle as that pass's last write. `rec_valid` rises in that cycle and stays high. The offset returns to 0.
- R7: `restart` closes any open pass and clears the offset to 0. It lowers `rec_valid` one cycle later and takes priority over `trig` and `smp_valid` in the same cycle. The next trigger starts offset 0.
- R8: With P = 1, a single pass writes slots 0 to `SAMPLES`-1 in order and closes the record (single-shot capture).
- R9: P is taken from `num_passes` only when a trigger opens the offset-0 pass. Changes on `num_passes` during a record have no effect. A value of 0 acts as 1, and values above `MAX_PASSES` act as `MAX_PASSES`.
- R10: A trigger that opens the offset-0 pass of a new record lowers `rec_valid` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Abandon the record and return to offset 0 |
| trig | input | 1 | Trigger pulse that opens a pass |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample value |
| num_passes | input | NP_W | Requested pass count P (clamped to 1..MAX_PASSES) |
| wr_en | output | 1 | Record memory write enable |
| wr_addr | output | ADDR_W | Record slot for the write |
| wr_data | output | DATA_W | Value to write |
| rec_done | output | 1 | One-cycle pulse when the record is complete |
| rec_valid | output | 1 | Record memory holds a complete record |

## Verification
A wrong sample counter or pass offset shows up on `wr_addr` at the very next write. Every written slot is compared on every clock, so the bench sees such an error within one sample. A stuck offset or a wrongly latched pass count can write the right slots in the first pass but wrong ones later. That error shows up either as a misplaced address in the second pass or as `rec_done` arriving one pass early or late. A phase machine that fails to ignore triggers or post-pass samples shows up as an unexpected `wr_en` in the same cycle stream. An interleaved read-back of the whole record after each completion then confirms that every slot holds the value of its own effective time point.

// File: rtl/et_pkg.sv
package et_pkg;

    typedef enum logic {
        PH_ARMED = 1'b0,
        PH_CAPT  = 1'b1
    } phase_t;

    // Bring a requested pass count into the legal range 1..maxp.
    function automatic int clamp_passes(input int req, input int maxp);
        if (req < 1)    return 1;
        if (req > maxp) return maxp;
        return req;
    endfunction

endpackage

// File: rtl/et_pass_ctrl.sv
module et_pass_ctrl #(
    parameter int SAMPLES    = 16,
    parameter int MAX_PASSES = 16,
    localparam int IDX_W = $clog2(SAMPLES),
    localparam int OFF_W = $clog2(MAX_PASSES),
    localparam int NP_W  = $clog2(MAX_PASSES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             trig,
    input  logic             smp_valid,
    input  logic [NP_W-1:0]  num_passes,
    output logic             accept,
    output logic [IDX_W-1:0] idx,
    output logic [OFF_W-1:0] off,
    output logic [NP_W-1:0]  passes,
    output logic             busy,
    output logic             rec_done,
    output logic             rec_valid
);
    import et_pkg::*;

    phase_t           phase_q;
    logic [IDX_W-1:0] idx_q;
    logic [OFF_W-1:0] off_q;
    logic [NP_W-1:0]  passes_q;
    logic             done_q;
    logic             valid_q;
    logic             pass_end;
    logic             rec_end;

    always_comb begin
        accept   = (phase_q == PH_CAPT) && smp_valid && !restart;
        pass_end = accept && (idx_q == IDX_W'(SAMPLES - 1));
        rec_end  = pass_end && ((NP_W'(off_q) + NP_W'(1)) == passes_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_ARMED;
            idx_q    <= '0;
            off_q    <= '0;
            passes_q <= NP_W'(1);
            done_q   <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (restart) begin
                phase_q <= PH_ARMED;
                idx_q   <= '0;
                off_q   <= '0;
                valid_q <= 1'b0;
            end else begin
                case (phase_q)
                    PH_ARMED: begin
                        if (trig) begin
                            phase_q <= PH_CAPT;
                            idx_q   <= '0;
                            if (off_q == '0) begin
                                passes_q <= NP_W'(clamp_passes(int'(num_passes), MAX_PASSES));
                                valid_q  <= 1'b0;
                            end
                        end
                    end
                    PH_CAPT: begin
                        if (accept) begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                        if (pass_end) begin
                            phase_q <= PH_ARMED;
                            idx_q   <= '0;
                            if (rec_end) begin
                                off_q   <= '0;
                                done_q  <= 1'b1;
                                valid_q <= 1'b1;
                            end else begin
                                off_q <= off_q + OFF_W'(1);
                            end
                        end
                    end
                    default: phase_q <= PH_ARMED;
                endcase
            end
        end
    end

    assign idx       = idx_q;
    assign off       = off_q;
    assign passes    = passes_q;
    assign busy      = (phase_q == PH_CAPT);
    assign rec_done  = done_q;
    assign rec_valid = valid_q;

endmodule

// File: rtl/et_slot_writer.sv
module et_slot_writer #(
    parameter int SAMPLES    = 16,
    parameter int MAX_PASSES = 16,
    parameter int DATA_W     = 8,
    localparam int IDX_W  = $clog2(SAMPLES),
    localparam int OFF_W  = $clog2(MAX_PASSES),
    localparam int NP_W   = $clog2(MAX_PASSES + 1),
    localparam int ADDR_W = $clog2(SAMPLES * MAX_PASSES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  off,
    input  logic [NP_W-1:0]   passes,
    input  logic [DATA_W-1:0] smp_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } slot_wr_t;

    slot_wr_t   nxt;
    slot_wr_t   cur;

    // Effective time position: sample number stretched by the pass count,
    // shifted by this pass's phase offset.
    always_comb begin
        nxt.en   = accept;
        nxt.addr = ADDR_W'(idx) * ADDR_W'(passes) + ADDR_W'(off);
        nxt.data = smp_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur.en <= nxt.en;
            if (nxt.en) begin
                cur.addr <= nxt.addr;
                cur.data <= nxt.data;
            end
        end
    end

    assign wr_en   = cur.en;
    assign wr_addr = cur.addr;
    assign wr_data = cur.data;

endmodule

// File: rtl/et_sample_placer.sv
module et_sample_placer #(
    parameter int SAMPLES    = 16,
    parameter int MAX_PASSES = 16,
    parameter int DATA_W     = 8,
    localparam int IDX_W  = $clog2(SAMPLES),
    localparam int OFF_W  = $clog2(MAX_PASSES),
    localparam int NP_W   = $clog2(MAX_PASSES + 1),
    localparam int ADDR_W = $clog2(SAMPLES * MAX_PASSES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              trig,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [NP_W-1:0]   num_passes,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rec_done,
    output logic              rec_valid
);
    logic             accept;
    logic [IDX_W-1:0] idx;
    logic [OFF_W-1:0] off;
    logic [NP_W-1:0]  passes;
    logic             busy;

    et_pass_ctrl #(
        .SAMPLES   (SAMPLES),
        .MAX_PASSES(MAX_PASSES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .trig      (trig),
        .smp_valid (smp_valid),
        .num_passes(num_passes),
        .accept    (accept),
        .idx       (idx),
        .off       (off),
        .passes    (passes),
        .busy      (busy),
        .rec_done  (rec_done),
        .rec_valid (rec_valid)
    );

    et_slot_writer #(
        .SAMPLES   (SAMPLES),
        .MAX_PASSES(MAX_PASSES),
        .DATA_W    (DATA_W)
    ) u_slot (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .idx     (idx),
        .off     (off),
        .passes  (passes),
        .smp_data(smp_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

endmodule

// File: rtl/et_placer_chk.sv
module et_placer_chk #(
    parameter int SAMPLES    = 16,
    parameter int MAX_PASSES = 16,
    localparam int NP_W   = $clog2(MAX_PASSES + 1),
    localparam int ADDR_W = $clog2(SAMPLES * MAX_PASSES)
) (
    input logic              clk,
    input logic              rst,
    input logic              restart,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rec_done,
    input logic              rec_valid,
    input logic [NP_W-1:0]   passes,
    input logic              busy
);
    // R2: a cycle spent waiting for a trigger accepts nothing, so no write follows
    p_no_write_when_armed_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> !wr_en);

    // R3: every written slot lies inside the span of the current pass count
    p_slot_in_span_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < SAMPLES * int'(passes)));

    // R6: completion is a single-cycle pulse
    p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        rec_done |=> !rec_done);

    // R6: completion coincides with the final write and a valid record
    p_done_with_write_r6: assert property (@(posedge clk) disable iff (rst)
        rec_done |-> (wr_en && rec_valid));

    // R6: the record becomes valid only through completion
    p_valid_rise_on_done_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_valid) |-> rec_done);

    // R7: restart silences the write port and drops the record
    p_restart_clears_r7: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!wr_en && !rec_valid && !rec_done));

endmodule

bind et_sample_placer et_placer_chk #(
    .SAMPLES   (SAMPLES),
    .MAX_PASSES(MAX_PASSES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rec_done (rec_done),
    .rec_valid(rec_valid),
    .passes   (passes),
    .busy     (busy)
);

// File: tb/sim_et_sample_placer.sv
`timescale 1ns/1ps
module sim_et_sample_placer;
    localparam int S      = 16;
    localparam int MAXP   = 16;
    localparam int DW     = 8;
    localparam int NP_W   = $clog2(MAXP + 1);
    localparam int ADDR_W = $clog2(S * MAXP);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst = 1'b1;
    logic              restart = 1'b0;
    logic              trig = 1'b0;
    logic              smp_valid = 1'b0;
    logic [DW-1:0]     smp_data = '0;
    logic [NP_W-1:0]   num_passes = NP_W'(1);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DW-1:0]     wr_data;
    logic              rec_done;
    logic              rec_valid;

    et_sample_placer #(.SAMPLES(S), .MAX_PASSES(MAXP), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .restart(restart), .trig(trig),
        .smp_valid(smp_valid), .smp_data(smp_data), .num_passes(num_passes),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rec_done(rec_done), .rec_valid(rec_valid)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    int    done_cnt = 0;
    bit    started = 0;
    int    rec_mem [S*MAXP];

    // Behavioural reference: phase, sample number, offset, pass count.
    int m_capt = 0, m_idx = 0, m_off = 0, m_p = 1, m_vld = 0;
    int e_we = 0, e_addr = 0, e_data = 0, e_done = 0;

    function automatic int wave(input int t, input int seed);
        return (t * 7 + seed * 13 + 3) % 256;
    endfunction

    always @(posedge clk) begin
        started = 1;
        e_we = 0;
        e_done = 0;
        if (rst) begin
            m_capt = 0; m_idx = 0; m_off = 0; m_p = 1; m_vld = 0;
        end else if (restart) begin
            m_capt = 0; m_idx = 0; m_off = 0; m_vld = 0;
        end else if (m_capt == 0) begin
            if (trig) begin
                m_capt = 1;
                m_idx = 0;
                if (m_off == 0) begin
                    m_p = (int'(num_passes) < 1) ? 1 : ((int'(num_passes) > MAXP) ? MAXP : int'(num_passes));
                    m_vld = 0;
                end
            end
        end else if (smp_valid) begin
            e_we = 1;
            e_addr = m_idx * m_p + m_off;
            e_data = int'(smp_data);
            m_idx++;
            if (m_idx == S) begin
                m_capt = 0;
                m_idx = 0;
                if (m_off == m_p - 1) begin
                    m_off = 0;
                    e_done = 1;
                    m_vld = 1;
                end else begin
                    m_off++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk(int'(wr_en) == e_we, "wr_en", int'(wr_en), e_we);
            if (e_we != 0 && wr_en) begin
                chk(int'(wr_addr) == e_addr, "wr_addr", int'(wr_addr), e_addr);
                chk(int'(wr_data) == e_data, "wr_data", int'(wr_data), e_data);
            end
            chk(int'(rec_done) == e_done, "rec_done", int'(rec_done), e_done);
            chk(int'(rec_valid) == m_vld, "rec_valid", int'(rec_valid), m_vld);
            if (wr_en) rec_mem[int'(wr_addr)] = int'(wr_data);
            if (rec_done) done_cnt++;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            trig = 0; smp_valid = 0; restart = 0;
        end
    endtask

    // One pass: trigger, then S samples with gaps, then junk after the pass.
    task automatic run_pass(input int p, input int off, input int seed, input bit mid_trig);
        int k;
        @(negedge clk);
        trig = 1; smp_valid = 0;
        k = 0;
        for (int c = 0; k < S; c++) begin
            @(negedge clk);
            trig = (mid_trig && c == 5) ? 1'b1 : 1'b0;
            if (c % 3 != 2) begin
                smp_valid = 1;
                smp_data = DW'(wave(k * p + off, seed));
                k++;
            end else begin
                smp_valid = 0;
            end
        end
        for (int j = 0; j < 3; j++) begin   // R5: samples after the pass end
            @(negedge clk);
            trig = 0; smp_valid = 1; smp_data = 8'hEE;
        end
        idle(2);
    endtask

    task automatic check_record(input int p, input int seed, input string t);
        tag = t;
        for (int s = 0; s < S * p; s++)
            chk(rec_mem[s] == wave(s, seed), "record slot", rec_mem[s], wave(s, seed));
    endtask

    initial begin : watchdog
        #(4 * 150000);
        checks++; fails++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        int d0;
        for (int s = 0; s < S * MAXP; s++) rec_mem[s] = -1;
        tag = "R1";
        repeat (3) @(negedge clk);
        chk(!wr_en && !rec_done && !rec_valid, "reset outputs", int'(wr_en | rec_done | rec_valid), 0);
        rst = 0;
        idle(2);

        // R2: samples without a trigger are dropped
        tag = "R2";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); smp_valid = 1; smp_data = 8'h5A;
        end
        idle(2);

        // R3, R4, R9: four passes, mid-pass trigger, pass count changed mid-record
        tag = "R3";
        num_passes = NP_W'(4);
        d0 = done_cnt;
        for (int ps = 0; ps < 4; ps++) begin
            if (ps == 1) begin tag = "R9"; num_passes = NP_W'(7); end
            if (ps == 2) tag = "R4";
            run_pass(4, ps, 1, ps == 2);
            if (ps < 3) begin
                tag = "R5";
                chk(done_cnt == d0, "no early completion", done_cnt, d0);
            end
        end
        tag = "R6";
        chk(done_cnt == d0 + 1, "one completion after four passes", done_cnt, d0 + 1);
        chk(rec_valid == 1'b1, "record valid held", int'(rec_valid), 1);
        check_record(4, 1, "R3");

        // R10: new record drops validity once its first pass opens
        tag = "R10";
        num_passes = NP_W'(2);
        @(negedge clk); trig = 1;
        @(negedge clk); trig = 0;
        chk(rec_valid == 1'b0, "valid cleared by new record", int'(rec_valid), 0);
        // finish this pass by hand: S samples at offset 0
        for (int k = 0; k < S; k++) begin
            @(negedge clk); smp_valid = 1; smp_data = DW'(wave(k * 2, 2));
        end
        idle(2);
        run_pass(2, 1, 2, 0);
        check_record(2, 2, "R10");

        // R8: single-shot capture
        tag = "R8";
        num_passes = NP_W'(1);
        d0 = done_cnt;
        run_pass(1, 0, 3, 0);
        chk(done_cnt == d0 + 1, "single pass completes", done_cnt, d0 + 1);
        check_record(1, 3, "R8");

        // R9: zero acts as one, oversize acts as MAX
        tag = "R9";
        num_passes = NP_W'(0);
        d0 = done_cnt;
        run_pass(1, 0, 4, 0);
        chk(done_cnt == d0 + 1, "zero passes acts as one", done_cnt, d0 + 1);
        num_passes = NP_W'(20);
        d0 = done_cnt;
        for (int ps = 0; ps < MAXP; ps++) begin
            run_pass(MAXP, ps, 5, 0);
            if (ps == MAXP - 2) chk(done_cnt == d0, "not done before last", done_cnt, d0);
        end
        chk(done_cnt == d0 + 1, "oversize clamps to max", done_cnt, d0 + 1);
        check_record(MAXP, 5, "R9");

        // R7: restart mid-record and mid-pass, and over a trigger
        tag = "R7";
        num_passes = NP_W'(3);
        run_pass(3, 0, 6, 0);
        run_pass(3, 1, 6, 0);
        @(negedge clk); trig = 1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); trig = 0; smp_valid = 1; smp_data = 8'h11;
        end
        @(negedge clk); restart = 1; trig = 1; smp_valid = 1;
        @(negedge clk); restart = 0; trig = 0;
        chk(rec_valid == 1'b0 && wr_en == 1'b0, "restart drops record", int'(rec_valid | wr_en), 0);
        for (int k = 0; k < 3; k++) begin   // trig was overridden: nothing written
            @(negedge clk); smp_valid = 1; smp_data = 8'h22;
        end
        idle(2);
        d0 = done_cnt;
        for (int ps = 0; ps < 3; ps++) run_pass(3, ps, 7, 0);
        chk(done_cnt == d0 + 1, "record after restart", done_cnt, d0 + 1);
        check_record(3, 7, "R7");

        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule